// File: doc/BRIEF.md
# Page-Aligned Serial EEPROM Write Master

This block is the host side of a serial EEPROM link. It copies a byte buffer of any length into the EEPROM, starting at any address. A single start pulse hands it a target address and a byte count. From then on it pulls payload bytes through a simple fetch port: it presents an offset and reads the byte back in the same cycle. It drives the four SPI wires itself in mode 0, and reports the end of the job with a one-cycle done pulse or a sticky error flag.

The EEPROM accepts at most one 32-byte page per program operation. If a burst runs past the end of a page, it wraps back to the start of that same page. To avoid this, the master cuts the payload into chunks that each end at or before a page boundary. Each chunk is sent as three steps:

1. A one-byte write-enable frame.
2. A program frame carrying the opcode, a 16-bit address and the chunk data.
3. Repeated status-read frames, until the busy bit of the status byte reads zero.

The last step has a bounded number of polls. When that bound runs out, the job is abandoned with an error.

Top module: `eeprom_page_writer`

## Requirements
- R1: While reset is held and right after it, cs_n is 1, sck is 0, and busy, done and error are 0.
- R2: The first chunk holds min(length, 32 - (start_addr mod 32)) bytes. Every later chunk holds min(remaining, 32) bytes. No program frame carries bytes from two pages.
- R3: Each chunk opens with a frame holding only the byte 0x06. This is followed by a frame holding 0x02, the address high byte, the address low byte, and then the chunk bytes in order. Every byte goes out MSB first.
- R4: After each program frame the master sends status-read frames, each made of the bytes 0x05 and 0x00. The busy flag is bit 0 of the second byte read back on miso. The next write-enable frame, or the end of the job, follows only a frame in which that bit is 0.
- R5: sck is 0 whenever cs_n is 1. mosi is stable at each rising sck edge, where the EEPROM samples it.
- R6: Inside a job, cs_n stays high for at least 2*HALF_DIV clock cycles between two frames.
- R7: After POLL_LIMIT status reads in a row with the busy bit at 1, the master returns cs_n high and starts no further frames. It sets error and leaves done low. error stays 1 until the next accepted start, and is 0 in the cycle after that start.
- R8: A start with length 0 raises done in the next cycle, leaves busy at 0 and produces no frame.
- R9: For a nonzero length, busy is 1 from the cycle after start until the cycle in which done pulses for exactly one cycle. busy falls in that same cycle.
- R10: The data byte at job offset k is fetched with fetch_ofs = k, and it is sent as the k-th payload byte of the job.
- R11: A start pulse while busy is 1 has no effect on the frames sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when the block is idle |
| start_addr | input | AW | First EEPROM byte address |
| length | input | LW | Number of bytes to write |
| fetch_ofs | output | LW | Offset of the payload byte being fetched |
| fetch_take | output | 1 | High in the cycle fetch_data is consumed |
| fetch_data | input | 8 | Payload byte at fetch_ofs, valid in the same cycle |
| cs_n | output | 1 | SPI chip select, active low |
| sck | output | 1 | SPI clock, idle low |
| mosi | output | 1 | SPI data to the EEPROM |
| miso | input | 1 | SPI data from the EEPROM |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle pulse when a job has completed |
| error | output | 1 | Sticky flag: poll limit exhausted |

## Verification
Only the start response has a fixed latency. busy, the zero-length done pulse and the clearing of error are all due exactly one clock after the edge that samples start. The bench checks them at the falling clock edge that follows.

All frame traffic is checked byte by byte, at the moment each byte completes on the serial lines. A behavioural EEPROM model decodes mosi and compares each byte against a queue of expected bytes, built from the chunk rule. Every frame end must match a marker in that queue.

Job completion has no fixed latency: it depends on how many polls the model answers as busy. The bench therefore waits for done or error within a bounded window. It then requires the expected queue to be empty, and the count of done pulses to match.

// File: rtl/eew_pkg.sv
package eew_pkg;

  localparam logic [7:0] OP_WEN  = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_GAP,
    ST_WEN,
    ST_PCMD,
    ST_AHI,
    ST_ALO,
    ST_DATA,
    ST_SCMD,
    ST_SBYTE
  } eew_state_e;

  // bytes that fit before the next page end, capped by what is left
  function automatic int unsigned chunk_len(int unsigned addr,
                                            int unsigned rem,
                                            int unsigned page);
    int unsigned room;
    room = page - (addr % page);
    return (rem < room) ? rem : room;
  endfunction

endpackage

// File: rtl/eew_spi_byte.sv
// Shifts one byte out in SPI mode 0 and keeps the last bit sampled.
module eew_spi_byte #(
  parameter int HALF_DIV = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       active,
  output logic       done,
  output logic       last_bit
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [HW-1:0] hcnt;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          half_end;

  assign half_end = (hcnt == HW'(HALF_DIV - 1));
  assign mosi     = sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hcnt     <= '0;
      sh       <= '0;
      bitn     <= '0;
      sck      <= 1'b0;
      active   <= 1'b0;
      done     <= 1'b0;
      last_bit <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        sh     <= tx;
        hcnt   <= '0;
        bitn   <= '0;
        sck    <= 1'b0;
      end else if (active) begin
        if (half_end) begin
          hcnt <= '0;
          if (!sck) begin
            sck      <= 1'b1;
            last_bit <= miso;
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bitn <= bitn + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          hcnt <= hcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eew_gap_timer.sv
// Counts CYC cycles after load and flags the last one.
module eew_gap_timer #(
  parameter int CYC = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int GW = $clog2(CYC + 1);

  logic [GW-1:0] cnt;

  assign expired = (cnt == GW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load)         cnt <= GW'(CYC);
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int AW         = 16,
  parameter int LW         = 16,
  parameter int PAGE       = 32,
  parameter int HALF_DIV   = 7,
  parameter int POLL_LIMIT = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] length,
  output logic [LW-1:0] fetch_ofs,
  output logic          fetch_take,
  input  logic [7:0]    fetch_data,
  output logic          cs_n,
  output logic          sck,
  output logic          mosi,
  input  logic          miso,
  output logic          busy,
  output logic          done,
  output logic          error
);
  import eew_pkg::*;

  localparam int PW      = $clog2(POLL_LIMIT + 1);
  localparam int GAP_CYC = 2 * HALF_DIV;

  eew_state_e    state, after_gap;
  logic [AW-1:0] cur_addr;
  logic [AW-1:0] chunk_page;
  logic [LW-1:0] remaining, idx, chunk_left;
  logic [PW-1:0] poll_cnt;
  logic          issued;

  logic          is_byte, eng_go, eng_active, eng_done, wip;
  logic          gap_over, enter_gap, rstat_gap;
  logic [7:0]    tx_byte;
  logic [15:0]   addr16;

  assign addr16  = 16'(cur_addr);
  assign is_byte = (state != ST_IDLE) && (state != ST_GAP);
  assign cs_n    = !is_byte;
  assign eng_go  = is_byte && !eng_active && !issued;

  assign fetch_ofs  = idx;
  assign fetch_take = eng_go && (state == ST_DATA);

  always_comb begin
    case (state)
      ST_WEN:  tx_byte = OP_WEN;
      ST_PCMD: tx_byte = OP_PROG;
      ST_AHI:  tx_byte = addr16[15:8];
      ST_ALO:  tx_byte = addr16[7:0];
      ST_DATA: tx_byte = fetch_data;
      ST_SCMD: tx_byte = OP_STAT;
      default: tx_byte = 8'h00;
    endcase
  end

  // after a status byte: another frame follows unless the job ends here
  assign rstat_gap = wip ? (poll_cnt != PW'(POLL_LIMIT - 1))
                         : (remaining != '0);

  assign enter_gap = eng_done &&
                     ((state == ST_WEN) ||
                      (state == ST_DATA && chunk_left == LW'(1)) ||
                      (state == ST_SBYTE && rstat_gap));

  eew_spi_byte #(.HALF_DIV(HALF_DIV)) u_byte (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (eng_go),
    .tx       (tx_byte),
    .miso     (miso),
    .sck      (sck),
    .mosi     (mosi),
    .active   (eng_active),
    .done     (eng_done),
    .last_bit (wip)
  );

  eew_gap_timer #(.CYC(GAP_CYC)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (enter_gap),
    .expired (gap_over)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      after_gap  <= ST_IDLE;
      cur_addr   <= '0;
      chunk_page <= '0;
      remaining  <= '0;
      idx        <= '0;
      chunk_left <= '0;
      poll_cnt   <= '0;
      issued     <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      error      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (eng_go) issued <= 1'b1;
      if (enter_gap) state <= ST_GAP;

      case (state)
        ST_IDLE: if (start) begin
          error <= 1'b0;
          if (length == '0) begin
            done <= 1'b1;
          end else begin
            busy      <= 1'b1;
            cur_addr  <= start_addr;
            remaining <= length;
            idx       <= '0;
            state     <= ST_WEN;
          end
        end
        ST_GAP: if (gap_over) state <= after_gap;
        default: ;
      endcase

      if (eng_done) begin
        issued <= 1'b0;
        case (state)
          ST_WEN: begin
            after_gap  <= ST_PCMD;
            chunk_left <= LW'(chunk_len(32'(cur_addr), 32'(remaining), PAGE));
            chunk_page <= cur_addr / AW'(PAGE);
          end
          ST_PCMD: state <= ST_AHI;
          ST_AHI:  state <= ST_ALO;
          ST_ALO:  state <= ST_DATA;
          ST_DATA: begin
            idx        <= idx + 1'b1;
            cur_addr   <= cur_addr + 1'b1;
            remaining  <= remaining - 1'b1;
            chunk_left <= chunk_left - 1'b1;
            after_gap  <= ST_SCMD;
            poll_cnt   <= '0;
          end
          ST_SCMD: state <= ST_SBYTE;
          ST_SBYTE: begin
            if (!wip) begin
              after_gap <= ST_WEN;
              if (remaining == '0) begin
                state <= ST_IDLE;
                busy  <= 1'b0;
                done  <= 1'b1;
              end
            end else if (poll_cnt == PW'(POLL_LIMIT - 1)) begin
              state <= ST_IDLE;
              busy  <= 1'b0;
              error <= 1'b1;
            end else begin
              poll_cnt  <= poll_cnt + 1'b1;
              after_gap <= ST_SCMD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eew_checker.sv
module eew_checker #(
  parameter int AW   = 16,
  parameter int LW   = 16,
  parameter int PAGE = 32,
  parameter int GAP  = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [LW-1:0] length,
  input logic          busy,
  input logic          done,
  input logic          error,
  input logic          cs_n,
  input logic          sck,
  input logic          fetch_take,
  input logic [AW-1:0] cur_addr,
  input logic [AW-1:0] chunk_page
);
  int unsigned hi_run;
  logic        job_frame;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) begin
      hi_run    <= 0;
      job_frame <= 1'b0;
    end else if (!cs_n) begin
      hi_run    <= 0;
      job_frame <= 1'b1;
    end else begin
      hi_run <= hi_run + 1;
    end
  end

  a_r5_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  a_r2_page_stay: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_take |-> ((cur_addr / AW'(PAGE)) == chunk_page));

  a_r6_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && job_frame) |-> (hi_run >= GAP));

  a_r7_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> (cs_n && !busy && !done));

  a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && length == '0) |=> (done && cs_n && !busy));

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || error));
endmodule

bind eeprom_page_writer eew_checker #(
  .AW(AW), .LW(LW), .PAGE(PAGE), .GAP(2 * HALF_DIV)
) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .length(length),
  .busy(busy), .done(done), .error(error), .cs_n(cs_n), .sck(sck),
  .fetch_take(fetch_take), .cur_addr(cur_addr), .chunk_page(chunk_page)
);

// File: tb/test_eeprom_page_writer.sv
`timescale 1ns/1ps
module test_eeprom_page_writer;
  localparam int HD = 2;
  localparam int PL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0;
  logic [15:0] length = '0;
  logic [15:0] fetch_ofs;
  logic        fetch_take;
  logic [7:0]  fetch_data;
  logic        cs_n, sck, mosi;
  logic        miso = 1'b0;
  logic        busy, done, error;

  int tests = 0;
  int fails = 0;
  logic [7:0] buf_mem [0:255];

  always #4 clk = ~clk;

  assign fetch_data = buf_mem[fetch_ofs[7:0]];

  eeprom_page_writer #(.HALF_DIV(HD), .POLL_LIMIT(PL)) i_eeprom_page_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .length(length), .fetch_ofs(fetch_ofs), .fetch_take(fetch_take),
    .fetch_data(fetch_data), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .busy(busy), .done(done), .error(error)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- expected frame stream (-1 marks a frame end)
  int    exp_q[$];
  string tag_q[$];

  task automatic push(input int b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic plan_job(input int addr, input int len, input int polls);
    int a, rem, k, n, p;
    a = addr; rem = len; k = 0;
    while (rem > 0) begin
      n = 32 - (a % 32);
      if (rem < n) n = rem;
      push(6, "R3 write-enable"); push(-1, "R3 frame end");
      push(2, "R3 opcode"); push((a >> 8) & 255, "R3 addr hi");
      push(a & 255, "R2 addr lo");
      for (int i = 0; i < n; i++) push(buf_mem[(k + i) & 255], "R10 data");
      push(-1, "R2 chunk end");
      p = (polls >= PL) ? PL : polls + 1;
      for (int i = 0; i < p; i++) begin
        push(5, "R4 status cmd"); push(0, "R4 status pad"); push(-1, "R4 frame end");
      end
      if (polls >= PL) break;
      a += n; rem -= n; k += n;
    end
  endtask

  // ---------------- behavioural EEPROM on the serial pins
  bit         armed = 0;
  logic [7:0] s_sh, s_first, s_out = 8'h00;
  int         s_bc = 0, s_pos = 0;
  int         wip_left = 0, busy_polls = 0;
  bit         wel = 0;
  int         cs_falls = 0;

  task automatic take_item(input int got);
    int e; string t;
    if (exp_q.size() == 0) begin
      check(0, "R3 unexpected item", got, -2);
    end else begin
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(e == got, t, got, e);
    end
  endtask

  always @(negedge cs_n) if (armed) begin
    s_bc = 0; s_pos = 0; cs_falls++;
  end

  always @(posedge sck) if (armed && !cs_n) begin
    s_sh = {s_sh[6:0], mosi};
    s_bc++;
    if (s_bc == 8) begin
      s_bc = 0;
      if (s_pos == 0) s_first = s_sh;
      take_item(int'(s_sh));
      if (s_pos == 0 && s_sh == 8'h05) s_out = {6'b0, wel, wip_left != 0};
      s_pos++;
    end
  end

  always @(negedge sck) if (armed && !cs_n) begin
    miso  = s_out[7];
    s_out = {s_out[6:0], 1'b0};
  end

  always @(posedge cs_n) if (armed) begin
    check(s_bc == 0, "R5 whole bytes per frame", s_bc, 0);
    take_item(-1);
    if (s_first == 8'h02) begin wip_left = busy_polls; wel = 0; end
    else if (s_first == 8'h06) wel = 1;
    else if (s_first == 8'h05 && wip_left > 0) wip_left--;
  end

  // ---------------- per-clock monitor and watchdog
  int  cyc = 0, hi_run = 0, done_cnt = 0;
  bit  frame_seen = 0;

  always @(negedge clk) begin
    cyc++;
    if (done) done_cnt++;
    if (armed) begin
      if (cs_n && sck) check(0, "R5 sck idle low", 1, 0);
      if (!busy) begin frame_seen = 0; hi_run = 0; end
      else if (cs_n) hi_run++;
      else begin
        if (frame_seen && hi_run > 0) check(hi_run >= 2 * HD, "R6 cs gap", hi_run, 2 * HD);
        frame_seen = 1; hi_run = 0;
      end
    end
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- job driver
  task automatic run_job(input int addr, input int len, input int polls,
                         input bit expect_err, input bit poke);
    int d0, w;
    busy_polls = polls;
    plan_job(addr, len, polls);
    d0 = done_cnt;
    @(negedge clk);
    start = 1; start_addr = 16'(addr); length = 16'(len);
    @(negedge clk);
    start = 0;
    check(busy == 1, "R9 busy after start", busy, 1);
    check(error == 0, "R7 error cleared by start", error, 0);
    if (poke) begin
      repeat (100) @(negedge clk);
      start = 1; start_addr = 16'h0000; length = 16'd5;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (!done && !error && w < 40000) begin @(negedge clk); w++; end
    if (expect_err) begin
      check(error == 1, "R7 error raised", error, 1);
      check(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
    end else begin
      check(done == 1 && busy == 0, "R9 done with busy low", {done, busy}, 2);
      @(negedge clk);
      check(done == 0, "R9 done one cycle", done, 0);
      check(done_cnt == d0 + 1, "R9 single done pulse", done_cnt - d0, 1);
    end
    check(exp_q.size() == 0, "R4 all frames sent", exp_q.size(), 0);
  endtask

  initial begin
    int f0;
    for (int i = 0; i < 256; i++) buf_mem[i] = 8'((i * 37 + 11) & 255);
    repeat (3) @(negedge clk);
    check(cs_n == 1 && sck == 0, "R1 bus idle in reset", {cs_n, sck}, 2);
    check({busy, done, error} == 3'b000, "R1 flags low in reset", {busy, done, error}, 0);
    rst_n = 1;
    @(negedge clk);
    armed = 1;
    check(cs_n == 1 && {busy, done, error} == 3'b000, "R1 idle after reset",
          {cs_n, busy, done, error}, 8);

    run_job(16'h0040, 32, 2, 0, 0);   // R2 aligned single page
    run_job(16'h0105, 70, 1, 0, 0);   // R2 chunks 27/32/11
    run_job(16'h1FFE, 3, 0, 0, 0);    // R2 chunks 2/1
    run_job(16'h0033, 1, 3, 0, 1);    // R11 start while busy ignored

    // R8 zero length
    f0 = cs_falls;
    @(negedge clk);
    start = 1; start_addr = 16'h0010; length = 16'd0;
    @(negedge clk);
    start = 0;
    check(done == 1, "R8 done next cycle", done, 1);
    check(busy == 0, "R8 busy stays low", busy, 0);
    repeat (30) @(negedge clk);
    check(cs_falls == f0, "R8 no frame", cs_falls - f0, 0);

    // R7 poll limit
    run_job(16'h0020, 4, 100, 1, 0);
    f0 = cs_falls;
    repeat (200) @(negedge clk);
    check(cs_falls == f0, "R7 bus quiet after error", cs_falls - f0, 0);
    check(error == 1, "R7 error sticky", error, 1);
    run_job(16'h00E0, 40, 0, 0, 0);   // R7 cleared, R2 32/8

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule